// File: doc/BRIEF.md
# Tag-Matched Operand Collector and Issue Stage

This block is the front end of one functional unit in a dataflow-style processor. A microinstruction token arrives on its own channel and names the unit that must run it, the operation, an 8-bit tag, a destination (unit ID plus input port number) and a flag that says whether the result tag is incremented. Operand words arrive separately on two numbered input ports, each word carrying its own tag. The block keeps one token at a time and waits until every operand the operation needs sits on its port with the same tag as the token. Then it fires a one-cycle integer operation.

The result leaves on a single valid/ready output with the destination unit ID and port copied from the token and a result tag that is either the token tag or the token tag plus one, modulo 256. An operand whose tag does not match is kept in that port's one-entry buffer and stalls that port until a token with its tag consumes it. A token addressed to another unit is taken and dropped. No new token is taken while a token waits or a result is still pending.

Top module: `fu_tag_frontend`

## Requirements
- R1: After reset `res_valid` is 0, `tok_ready` is 1 and both bits of `opd_ready` are 1.
- R2: A held token fires only when every operand it needs is buffered with a tag equal to the token tag; with one needed operand missing no result appears.
- R3: An accepted operand stays buffered and drives its `opd_ready` bit low until a firing token with the same tag consumes it; an operand on a port the operation does not need is left in place.
- R4: Opcodes 5, 6 and 7 need no operands: the result (data 0) is valid two clock edges after the token handshake edge, and no operand buffer is consumed.
- R5: The result tag equals the token tag plus the increment flag, modulo 256 (tag 255 with the flag set gives 0).
- R6: `res_dst_uid` and `res_dst_port` equal the destination fields of the token that produced the result.
- R7: Opcode encoding: 0 = port0 + port1, 1 = port0 - port1 (modulo 2^32), 2 = bitwise AND, 3 = bitwise OR, 4 = pass port0 and need only port0.
- R8: While `res_valid` is 1 and `res_ready` is 0 all result outputs hold their values, and `tok_ready` is 0 while a token is held or a result is pending.
- R9: A token whose `tok_uid` differs from parameter `UNIT_ID` (default 1) is accepted and discarded: no result is produced and `tok_ready` is 1 on the next cycle.
- R10: The result does not depend on order of arrival: operands may arrive before or after their token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tok_valid | input | 1 | Token offered |
| tok_ready | output | 1 | Token can be taken this cycle |
| tok_uid | input | UID_W | Unit that must execute the token |
| tok_op | input | 3 | Operation code |
| tok_tag | input | TAG_W | Token tag |
| tok_dst_uid | input | UID_W | Destination unit of the result |
| tok_dst_port | input | PORT_W | Destination input port of the result |
| tok_inc | input | 1 | Increment result tag when 1 |
| opd_valid | input | 2 | Operand offered, one bit per port |
| opd_ready | output | 2 | Operand port buffer empty, one bit per port |
| opd_tag | input | 2*TAG_W | Operand tags, port p in bits p*TAG_W upward |
| opd_data | input | 2*DATA_W | Operand words, port p in bits p*DATA_W upward |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result taken |
| res_data | output | DATA_W | Result word |
| res_tag | output | TAG_W | Result tag |
| res_dst_uid | output | UID_W | Destination unit |
| res_dst_port | output | PORT_W | Destination port |

## Verification
The assertions assume that the token and operand sources obey valid/ready: held fields do not change before their handshake, and inputs are never X after reset. They also take for granted that the source never lets a mismatched operand block a port that the held token needs, since that case stalls by intent. The stimulus drives each offer at a falling edge, holds it until the handshake edge, and orders operands so that every held token can eventually be satisfied.

// File: rtl/fu_tag_pkg.sv
// Shared constants for the tag-matched front end.
// Assumes a fixed three-bit operation code and two operand ports.
package fu_tag_pkg;
    localparam int OP_W      = 3;
    localparam int OPD_PORTS = 2;

    localparam logic [OP_W-1:0] OP_ADD  = 3'd0;
    localparam logic [OP_W-1:0] OP_SUB  = 3'd1;
    localparam logic [OP_W-1:0] OP_AND  = 3'd2;
    localparam logic [OP_W-1:0] OP_OR   = 3'd3;
    localparam logic [OP_W-1:0] OP_PASS = 3'd4;

    // Which operand ports an operation waits for (bit p = port p).
    function automatic logic [OPD_PORTS-1:0] need_of(input logic [OP_W-1:0] op);
        case (op)
            OP_ADD, OP_SUB, OP_AND, OP_OR: need_of = 2'b11;
            OP_PASS:                       need_of = 2'b01;
            default:                       need_of = 2'b00;
        endcase
    endfunction
endpackage

// File: rtl/fu_opd_slot.sv
// One-entry operand buffer for a single input port.
// Holds a tagged word from acceptance until the issue logic consumes it;
// the port is ready only while empty. Assumes consume only when full.
module fu_opd_slot #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_data,
    input  logic              consume,
    output logic              full,
    output logic [TAG_W-1:0]  slot_tag,
    output logic [DATA_W-1:0] slot_data
);
    assign in_ready = !full;

    // Fill on handshake, empty on consume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full      <= 1'b0;
            slot_tag  <= '0;
            slot_data <= '0;
        end else if (in_valid && in_ready) begin
            full      <= 1'b1;
            slot_tag  <= in_tag;
            slot_data <= in_data;
        end else if (consume) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/fu_tok_hold.sv
// Current-token register. Accepts a token when nothing is held and no
// result is pending; tokens for another unit are taken and dropped.
// Releases the token on the fire pulse.
module fu_tok_hold #(
    parameter int          UID_W   = 4,
    parameter int          TAG_W   = 8,
    parameter int          PORT_W  = 2,
    parameter int          OP_W    = 3,
    parameter logic [UID_W-1:0] UNIT_ID = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    output logic              tok_ready,
    input  logic [UID_W-1:0]  tok_uid,
    input  logic [OP_W-1:0]   tok_op,
    input  logic [TAG_W-1:0]  tok_tag,
    input  logic [UID_W-1:0]  tok_dst_uid,
    input  logic [PORT_W-1:0] tok_dst_port,
    input  logic              tok_inc,
    input  logic              res_busy,
    input  logic              fire,
    output logic              held,
    output logic [OP_W-1:0]   h_op,
    output logic [TAG_W-1:0]  h_tag,
    output logic [UID_W-1:0]  h_dst_uid,
    output logic [PORT_W-1:0] h_dst_port,
    output logic              h_inc
);
    logic take;

    // Accept only when idle and the output stage is free.
    assign tok_ready = !held && !res_busy;
    assign take      = tok_valid && tok_ready && (tok_uid == UNIT_ID);

    // Hold the token fields until the operation fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held       <= 1'b0;
            h_op       <= '0;
            h_tag      <= '0;
            h_dst_uid  <= '0;
            h_dst_port <= '0;
            h_inc      <= 1'b0;
        end else if (take) begin
            held       <= 1'b1;
            h_op       <= tok_op;
            h_tag      <= tok_tag;
            h_dst_uid  <= tok_dst_uid;
            h_dst_port <= tok_dst_port;
            h_inc      <= tok_inc;
        end else if (fire) begin
            held <= 1'b0;
        end
    end
endmodule

// File: rtl/fu_exec_out.sv
// Single-cycle integer operation and result register with valid/ready.
// Computes on the fire pulse and holds the result until it is taken.
// Assumes fire is never raised while a result is pending.
module fu_exec_out #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 8,
    parameter int UID_W  = 4,
    parameter int PORT_W = 2,
    parameter int OP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [TAG_W-1:0]  tag,
    input  logic              inc,
    input  logic [UID_W-1:0]  dst_uid,
    input  logic [PORT_W-1:0] dst_port,
    input  logic              res_ready,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [TAG_W-1:0]  res_tag,
    output logic [UID_W-1:0]  res_dst_uid,
    output logic [PORT_W-1:0] res_dst_port
);
    import fu_tag_pkg::*;

    logic [DATA_W-1:0] alu_y;
    logic [TAG_W-1:0]  tag_next;

    // Operation select.
    always_comb begin
        case (op)
            OP_ADD:  alu_y = a + b;
            OP_SUB:  alu_y = a - b;
            OP_AND:  alu_y = a & b;
            OP_OR:   alu_y = a | b;
            OP_PASS: alu_y = a;
            default: alu_y = '0;
        endcase
    end

    // Result tag, wrapping at the tag width.
    assign tag_next = tag + {{(TAG_W-1){1'b0}}, inc};

    // Load on fire, clear valid on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_data     <= '0;
            res_tag      <= '0;
            res_dst_uid  <= '0;
            res_dst_port <= '0;
        end else if (fire) begin
            res_valid    <= 1'b1;
            res_data     <= alu_y;
            res_tag      <= tag_next;
            res_dst_uid  <= dst_uid;
            res_dst_port <= dst_port;
        end else if (res_valid && res_ready) begin
            res_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/fu_tag_frontend.sv
// Tag-matched functional unit front end. Buffers one token and one operand
// per port, fires when all needed operands carry the token's tag and the
// output is free, and emits a routed, retagged result.
// Assumes sources keep offers stable until their handshake.
module fu_tag_frontend #(
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 8,
    parameter int UID_W   = 4,
    parameter int PORT_W  = 2,
    parameter logic [UID_W-1:0] UNIT_ID = 1
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   tok_valid,
    output logic                                   tok_ready,
    input  logic [UID_W-1:0]                       tok_uid,
    input  logic [2:0]                             tok_op,
    input  logic [TAG_W-1:0]                       tok_tag,
    input  logic [UID_W-1:0]                       tok_dst_uid,
    input  logic [PORT_W-1:0]                      tok_dst_port,
    input  logic                                   tok_inc,
    input  logic [1:0]                             opd_valid,
    output logic [1:0]                             opd_ready,
    input  logic [2*TAG_W-1:0]                     opd_tag,
    input  logic [2*DATA_W-1:0]                    opd_data,
    output logic                                   res_valid,
    input  logic                                   res_ready,
    output logic [DATA_W-1:0]                      res_data,
    output logic [TAG_W-1:0]                       res_tag,
    output logic [UID_W-1:0]                       res_dst_uid,
    output logic [PORT_W-1:0]                      res_dst_port
);
    import fu_tag_pkg::*;

    localparam int NP = OPD_PORTS;

    logic              held;
    logic [OP_W-1:0]   h_op;
    logic [TAG_W-1:0]  h_tag;
    logic [UID_W-1:0]  h_dst_uid;
    logic [PORT_W-1:0] h_dst_port;
    logic              h_inc;
    logic              fire;
    logic [NP-1:0]     need;
    logic [NP-1:0]     match;
    logic [NP-1:0]     slot_full;
    logic [NP-1:0]     consume;
    logic [TAG_W-1:0]  slot_tag  [NP];
    logic [DATA_W-1:0] slot_data [NP];

    fu_tok_hold #(
        .UID_W(UID_W), .TAG_W(TAG_W), .PORT_W(PORT_W),
        .OP_W(OP_W), .UNIT_ID(UNIT_ID)
    ) u_tok (
        .clk(clk), .rst_n(rst_n),
        .tok_valid(tok_valid), .tok_ready(tok_ready),
        .tok_uid(tok_uid), .tok_op(tok_op), .tok_tag(tok_tag),
        .tok_dst_uid(tok_dst_uid), .tok_dst_port(tok_dst_port),
        .tok_inc(tok_inc), .res_busy(res_valid), .fire(fire),
        .held(held), .h_op(h_op), .h_tag(h_tag),
        .h_dst_uid(h_dst_uid), .h_dst_port(h_dst_port), .h_inc(h_inc)
    );

    // Operands the held operation waits for.
    assign need = need_of(h_op);

    for (genvar p = 0; p < NP; p++) begin : g_port
        fu_opd_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .in_valid(opd_valid[p]), .in_ready(opd_ready[p]),
            .in_tag(opd_tag[p*TAG_W +: TAG_W]),
            .in_data(opd_data[p*DATA_W +: DATA_W]),
            .consume(consume[p]), .full(slot_full[p]),
            .slot_tag(slot_tag[p]), .slot_data(slot_data[p])
        );

        // Port is satisfied when not needed or holding the token's tag.
        assign match[p]   = !need[p] || (slot_full[p] && slot_tag[p] == h_tag);
        assign consume[p] = fire && need[p];
    end

    // Issue condition: token held, all operands matched, output free.
    assign fire = held && !res_valid && (&match);

    fu_exec_out #(
        .DATA_W(DATA_W), .TAG_W(TAG_W), .UID_W(UID_W),
        .PORT_W(PORT_W), .OP_W(OP_W)
    ) u_exec (
        .clk(clk), .rst_n(rst_n), .fire(fire), .op(h_op),
        .a(slot_data[0]), .b(slot_data[1]), .tag(h_tag), .inc(h_inc),
        .dst_uid(h_dst_uid), .dst_port(h_dst_port),
        .res_ready(res_ready), .res_valid(res_valid),
        .res_data(res_data), .res_tag(res_tag),
        .res_dst_uid(res_dst_uid), .res_dst_port(res_dst_port)
    );
endmodule

// File: rtl/fu_tag_frontend_chk.sv
// Protocol and timing checks for fu_tag_frontend, attached by bind.
// Keeps a shadow of the last accepted token to predict result routing.
module fu_tag_frontend_chk #(
    parameter int TAG_W  = 8,
    parameter int UID_W  = 4,
    parameter int PORT_W = 2,
    parameter int DATA_W = 32,
    parameter logic [UID_W-1:0] UNIT_ID = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tok_valid,
    input logic              tok_ready,
    input logic [UID_W-1:0]  tok_uid,
    input logic [2:0]        tok_op,
    input logic [TAG_W-1:0]  tok_tag,
    input logic [UID_W-1:0]  tok_dst_uid,
    input logic [PORT_W-1:0] tok_dst_port,
    input logic              tok_inc,
    input logic [1:0]        opd_valid,
    input logic [1:0]        opd_ready,
    input logic              res_valid,
    input logic              res_ready,
    input logic [DATA_W-1:0] res_data,
    input logic [TAG_W-1:0]  res_tag,
    input logic [UID_W-1:0]  res_dst_uid,
    input logic [PORT_W-1:0] res_dst_port
);
    logic              acc_own;
    logic [TAG_W-1:0]  sh_tag;
    logic              sh_inc;
    logic [UID_W-1:0]  sh_uid;
    logic [PORT_W-1:0] sh_port;

    assign acc_own = tok_valid && tok_ready && (tok_uid == UNIT_ID);

    // Shadow copy of the accepted token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_tag <= '0; sh_inc <= 1'b0; sh_uid <= '0; sh_port <= '0;
        end else if (acc_own) begin
            sh_tag <= tok_tag; sh_inc <= tok_inc;
            sh_uid <= tok_dst_uid; sh_port <= tok_dst_port;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !res_valid);

    a_r3_port0_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        opd_valid[0] && opd_ready[0] |=> !opd_ready[0]);

    a_r3_port1_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        opd_valid[1] && opd_ready[1] |=> !opd_ready[1]);

    a_r4_zero_op_fires: assert property (@(posedge clk) disable iff (!rst_n)
        acc_own && tok_op >= 3'd5 |-> ##2 res_valid);

    a_r5_result_tag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> res_tag == TAG_W'(sh_tag + {{(TAG_W-1){1'b0}}, sh_inc}));

    a_r6_routing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> res_dst_uid == sh_uid && res_dst_port == sh_port);

    a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_tag)
            && $stable(res_dst_uid) && $stable(res_dst_port));

    a_r8_no_token_pending: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !tok_ready);

    a_r9_foreign_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_ready && tok_uid != UNIT_ID |=> tok_ready && !res_valid);
endmodule

bind fu_tag_frontend fu_tag_frontend_chk #(
    .TAG_W(TAG_W), .UID_W(UID_W), .PORT_W(PORT_W),
    .DATA_W(DATA_W), .UNIT_ID(UNIT_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
    .tok_uid(tok_uid), .tok_op(tok_op), .tok_tag(tok_tag),
    .tok_dst_uid(tok_dst_uid), .tok_dst_port(tok_dst_port), .tok_inc(tok_inc),
    .opd_valid(opd_valid), .opd_ready(opd_ready),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_tag(res_tag), .res_dst_uid(res_dst_uid), .res_dst_port(res_dst_port)
);

// File: tb/fu_tag_frontend_tb.sv
// Directed bench for fu_tag_frontend: one task per scenario.
module fu_tag_frontend_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_valid = 1'b0;
    logic        tok_ready;
    logic [3:0]  tok_uid = '0;
    logic [2:0]  tok_op = '0;
    logic [7:0]  tok_tag = '0;
    logic [3:0]  tok_dst_uid = '0;
    logic [1:0]  tok_dst_port = '0;
    logic        tok_inc = 1'b0;
    logic [1:0]  opd_valid = '0;
    logic [1:0]  opd_ready;
    logic [15:0] opd_tag = '0;
    logic [63:0] opd_data = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic [31:0] res_data;
    logic [7:0]  res_tag;
    logic [3:0]  res_dst_uid;
    logic [1:0]  res_dst_port;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fu_tag_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
        .tok_uid(tok_uid), .tok_op(tok_op), .tok_tag(tok_tag),
        .tok_dst_uid(tok_dst_uid), .tok_dst_port(tok_dst_port), .tok_inc(tok_inc),
        .opd_valid(opd_valid), .opd_ready(opd_ready), .opd_tag(opd_tag),
        .opd_data(opd_data), .res_valid(res_valid), .res_ready(res_ready),
        .res_data(res_data), .res_tag(res_tag), .res_dst_uid(res_dst_uid),
        .res_dst_port(res_dst_port)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_tok(input logic [3:0] uid, input logic [2:0] op, input logic [7:0] tag,
                            input logic [3:0] du, input logic [1:0] dp, input logic inc);
        @(negedge clk);
        tok_uid = uid; tok_op = op; tok_tag = tag;
        tok_dst_uid = du; tok_dst_port = dp; tok_inc = inc; tok_valid = 1'b1;
        while (!tok_ready) @(negedge clk);
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic send_opd(input int p, input logic [7:0] tag, input logic [31:0] d);
        @(negedge clk);
        opd_tag[p*8 +: 8] = tag; opd_data[p*32 +: 32] = d; opd_valid[p] = 1'b1;
        while (!opd_ready[p]) @(negedge clk);
        @(negedge clk);
        opd_valid[p] = 1'b0;
    endtask

    task automatic get_result(input string req, input logic [31:0] d, input logic [7:0] tag,
                              input logic [3:0] du, input logic [1:0] dp);
        int waited = 0;
        while (!res_valid && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        check({req, " valid"}, {31'd0, res_valid}, 32'd1);
        check({req, " data"}, res_data, d);
        check({req, " tag"}, {24'd0, res_tag}, {24'd0, tag});
        check({req, " R6 dst"}, {26'd0, res_dst_uid, res_dst_port}, {26'd0, du, dp});
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 res_valid", {31'd0, res_valid}, 32'd0);
        check("R1 tok_ready", {31'd0, tok_ready}, 32'd1);
        check("R1 opd_ready", {30'd0, opd_ready}, 32'd3);
    endtask

    task automatic t_operands_first;   // R10, R7 add, R5 increment
        send_opd(0, 8'd5, 32'd10);
        send_opd(1, 8'd5, 32'd20);
        check("R10 no result before token", {31'd0, res_valid}, 32'd0);
        send_tok(4'd1, 3'd0, 8'd5, 4'd3, 2'd2, 1'b1);
        get_result("R7 add R5", 32'd30, 8'd6, 4'd3, 2'd2);
    endtask

    task automatic t_token_first;      // R2, R10, R7 sub
        send_tok(4'd1, 3'd1, 8'd9, 4'd2, 2'd1, 1'b0);
        send_opd(0, 8'd9, 32'd100);
        idle(2);
        check("R2 waits for port1", {31'd0, res_valid}, 32'd0);
        send_opd(1, 8'd9, 32'd30);
        get_result("R10 R7 sub", 32'd70, 8'd9, 4'd2, 2'd1);
    endtask

    task automatic t_mismatch;         // R3, R7 pass and or
        send_opd(1, 8'd7, 32'h55);
        send_tok(4'd1, 3'd4, 8'd6, 4'd5, 2'd0, 1'b0);
        idle(1);
        check("R2 pass waits for port0", {31'd0, res_valid}, 32'd0);
        send_opd(0, 8'd6, 32'h11);
        get_result("R7 pass", 32'h11, 8'd6, 4'd5, 2'd0);
        check("R3 mismatched port1 still blocked", {31'd0, opd_ready[1]}, 32'd0);
        send_tok(4'd1, 3'd3, 8'd7, 4'd6, 2'd3, 1'b1);
        send_opd(0, 8'd7, 32'h0A);
        get_result("R3 R7 or", 32'h5F, 8'd8, 4'd6, 2'd3);
        check("R3 port1 freed", {31'd0, opd_ready[1]}, 32'd1);
    endtask

    task automatic t_zero_op;          // R4, R5 wrap
        send_opd(0, 8'd50, 32'd7);
        send_tok(4'd1, 3'd5, 8'd255, 4'd9, 2'd1, 1'b1);
        check("R4 not valid after one edge", {31'd0, res_valid}, 32'd0);
        @(negedge clk);
        check("R4 valid after two edges", {31'd0, res_valid}, 32'd1);
        get_result("R4 R5 wrap", 32'd0, 8'd0, 4'd9, 2'd1);
        check("R4 port0 untouched", {31'd0, opd_ready[0]}, 32'd0);
        send_tok(4'd1, 3'd4, 8'd50, 4'd1, 2'd0, 1'b0);
        get_result("R4 kept operand", 32'd7, 8'd50, 4'd1, 2'd0);
    endtask

    task automatic t_backpressure;     // R8, R7 and
        send_opd(0, 8'd20, 32'hF0F0);
        send_opd(1, 8'd20, 32'hFF00);
        send_tok(4'd1, 3'd2, 8'd20, 4'd4, 2'd3, 1'b0);
        idle(4);
        check("R8 valid held", {31'd0, res_valid}, 32'd1);
        check("R8 data held", res_data, 32'hF000);
        check("R8 tok_ready low", {31'd0, tok_ready}, 32'd0);
        get_result("R8 R7 and", 32'hF000, 8'd20, 4'd4, 2'd3);
    endtask

    task automatic t_foreign;          // R9
        send_tok(4'd2, 3'd5, 8'd1, 4'd1, 2'd1, 1'b0);
        check("R9 tok_ready after drop", {31'd0, tok_ready}, 32'd1);
        idle(3);
        check("R9 no result", {31'd0, res_valid}, 32'd0);
    endtask

    task automatic t_sub_wrap;         // R7 modulo subtract
        send_tok(4'd1, 3'd1, 8'd33, 4'd7, 2'd2, 1'b1);
        send_opd(1, 8'd33, 32'd5);
        send_opd(0, 8'd33, 32'd3);
        get_result("R7 sub wrap", 32'hFFFF_FFFE, 8'd34, 4'd7, 2'd2);
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_operands_first();
        t_token_first();
        t_mismatch();
        t_zero_op();
        t_backpressure();
        t_foreign();
        t_sub_wrap();
        idle(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule